// File: doc/BRIEF.md
# DMA Fault and Halt Status Flags

This block keeps two sticky status flags for a multi-channel DMA controller and drives one suspend line to every channel engine. One flag records a bus address fault seen during a transfer. The other records a non-maskable interrupt. When either flag is set, all channels are halted. An address fault halts them at once. For an interrupt, the transfer unit in flight is first allowed to complete.

Software reads the flags through a small strobe interface and clears them with a guarded sequence. Software cannot set a flag. A flag is cleared only by writing 0 to its bit after a read that returned 1 for that flag. Any write in between removes the right to clear, so a fault that arrives between the read and the write is not lost.

Top module: `dma_halt_flags`

## Requirements
- R1: A pulse on `addr_err_evt` makes the fault flag read as 1, at bit `ERR_POS` of `rd_data`, on every read from the following cycle until the flag is cleared.
- R2: `suspend_all` is high in the cycle after an `addr_err_evt` pulse.
- R3: A pulse on `nmi_evt` sets the interrupt flag, at bit `NMI_POS` of `rd_data`. This happens whatever the level of `dma_active`.
- R4: After `nmi_evt` with `dma_active` low, `suspend_all` is high in the next cycle. With `dma_active` high, `suspend_all` stays low until `unit_done` is sampled high, and it rises in the cycle after that strobe.
- R5: A write with a 1 in a flag's bit position never sets that flag and never clears it.
- R6: A write of 0 clears a flag only if the most recent access before it was a read that returned 1 for that flag. Otherwise the flag keeps its value.
- R7: Every write withdraws the clear permission from both flags. A second write of 0 that follows a write needs a fresh read before it can clear.
- R8: If a set event and a permitted clear land in the same cycle, the flag stays set.
- R9: `suspend_all` stays high while either flag is set. It falls in the same cycle as the flag that clears last.
- R10: On `rd_stb`, `rd_data` loads the flag values from that cycle in the next cycle, with every other bit 0. It holds between reads and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_err_evt | input | 1 | Address fault event pulse |
| nmi_evt | input | 1 | Non-maskable interrupt event pulse |
| dma_active | input | 1 | A transfer is in progress |
| unit_done | input | 1 | Current transfer unit finished |
| rd_stb | input | 1 | Status register read strobe |
| wr_stb | input | 1 | Status register write strobe |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Registered read data |
| suspend_all | output | 1 | Halt request to every channel |

## Verification
The bench builds the block with `REG_W` = 16, `ERR_POS` = 9 and `NMI_POS` = 4. The flags therefore sit in the middle of the word, away from the low bits. Flags landing at the wrong position, or stray bits in the unused positions, show up in the full-word compare of `rd_data`. The separated positions also let a single write carry 0 for one flag and 1 for the other. That exposes any mix-up between the two clear paths while both flags are pending.

// File: rtl/dma_halt_pkg.sv
package dma_halt_pkg;
  localparam int FLAG_N   = 2;
  localparam int FLAG_ERR = 0;
  localparam int FLAG_NMI = 1;
endpackage

// File: rtl/dma_halt_flag_cell.sv
// One sticky status flag with a read-then-write-zero clear guard.
module dma_halt_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_d,
  output logic flag_q
);
  logic armed_q;
  logic clr_ok;

  // A clear is allowed only while armed and only with a 0 in the flag's bit.
  assign clr_ok = wr_stb & armed_q & ~wr_bit;
  // A set event wins over a clear in the same cycle.
  assign flag_d = set_evt | (flag_q & ~clr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_stb)
        armed_q <= 1'b0;
      else if (rd_stb)
        armed_q <= flag_q;
    end
  end
endmodule

// File: rtl/dma_halt_gate.sv
// Builds the suspend request from the next-state flag values.
module dma_halt_gate (
  input  logic clk,
  input  logic rst,
  input  logic err_d,
  input  logic nmi_d,
  input  logic dma_active,
  input  logic unit_done,
  output logic suspend_q
);
  logic nmi_gate_q;
  logic nmi_gate_d;
  logic suspend_d;

  // The interrupt halt is held back while a unit is in flight.
  assign nmi_gate_d = nmi_d & (nmi_gate_q | ~dma_active | unit_done);
  assign suspend_d  = err_d | nmi_gate_d | (suspend_q & nmi_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_gate_q <= 1'b0;
      suspend_q  <= 1'b0;
    end else begin
      nmi_gate_q <= nmi_gate_d;
      suspend_q  <= suspend_d;
    end
  end
endmodule

// File: rtl/dma_halt_rd_pack.sv
// Registered read port: places the flags at their positions.
module dma_halt_rd_pack #(
  parameter int REG_W   = 8,
  parameter int ERR_POS = 1,
  parameter int NMI_POS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic [1:0]       flags_q,
  output logic [REG_W-1:0] rd_data
);
  import dma_halt_pkg::*;
  logic [REG_W-1:0] word;

  always_comb begin
    word          = '0;
    word[ERR_POS] = flags_q[FLAG_ERR];
    word[NMI_POS] = flags_q[FLAG_NMI];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_stb)
      rd_data <= word;
  end
endmodule

// File: rtl/dma_halt_flags.sv
module dma_halt_flags #(
  parameter int REG_W   = 8,
  parameter int ERR_POS = 1,
  parameter int NMI_POS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_err_evt,
  input  logic             nmi_evt,
  input  logic             dma_active,
  input  logic             unit_done,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             suspend_all
);
  import dma_halt_pkg::*;

  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] flags_d;
  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] wr_bits;
  logic              wr_unused;

  assign set_vec[FLAG_ERR] = addr_err_evt;
  assign set_vec[FLAG_NMI] = nmi_evt;
  assign wr_bits[FLAG_ERR] = wr_data[ERR_POS];
  assign wr_bits[FLAG_NMI] = wr_data[NMI_POS];
  assign wr_unused         = ^wr_data;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    dma_halt_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .set_evt (set_vec[i]),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .wr_bit  (wr_bits[i]),
      .flag_d  (flags_d[i]),
      .flag_q  (flags_q[i])
    );
  end

  dma_halt_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .err_d      (flags_d[FLAG_ERR]),
    .nmi_d      (flags_d[FLAG_NMI]),
    .dma_active (dma_active),
    .unit_done  (unit_done),
    .suspend_q  (suspend_all)
  );

  dma_halt_rd_pack #(
    .REG_W   (REG_W),
    .ERR_POS (ERR_POS),
    .NMI_POS (NMI_POS)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .flags_q (flags_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dma_halt_flags_chk.sv
module dma_halt_flags_chk #(
  parameter int REG_W   = 8,
  parameter int ERR_POS = 1,
  parameter int NMI_POS = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             addr_err_evt,
  input logic             nmi_evt,
  input logic             dma_active,
  input logic             unit_done,
  input logic             wr_stb,
  input logic [REG_W-1:0] rd_data,
  input logic             suspend_all,
  input logic [1:0]       flags_q
);
  import dma_halt_pkg::*;
  localparam logic [REG_W-1:0] USED = (REG_W'(1) << ERR_POS) | (REG_W'(1) << NMI_POS);

  a_r1_err_sets: assert property (@(posedge clk) disable iff (rst)
    addr_err_evt |=> flags_q[FLAG_ERR]);
  a_r2_err_suspends: assert property (@(posedge clk) disable iff (rst)
    addr_err_evt |=> suspend_all);
  a_r3_nmi_sets: assert property (@(posedge clk) disable iff (rst)
    nmi_evt |=> flags_q[FLAG_NMI]);
  a_r4_nmi_idle: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && !dma_active) |=> suspend_all);
  a_r4_nmi_waits: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && dma_active && !unit_done && !addr_err_evt && !flags_q[FLAG_ERR] && !suspend_all)
      |=> !suspend_all);
  a_r5_no_err_from_write: assert property (@(posedge clk) disable iff (rst)
    (!addr_err_evt && !flags_q[FLAG_ERR]) |=> !flags_q[FLAG_ERR]);
  a_r5_no_nmi_from_write: assert property (@(posedge clk) disable iff (rst)
    (!nmi_evt && !flags_q[FLAG_NMI]) |=> !flags_q[FLAG_NMI]);
  a_r6_err_kept: assert property (@(posedge clk) disable iff (rst)
    (flags_q[FLAG_ERR] && !wr_stb) |=> flags_q[FLAG_ERR]);
  a_r9_err_holds_suspend: assert property (@(posedge clk) disable iff (rst)
    flags_q[FLAG_ERR] |-> suspend_all);
  a_r9_suspend_needs_flag: assert property (@(posedge clk) disable iff (rst)
    suspend_all |-> (flags_q != 2'b00));
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~USED) == '0);
endmodule

bind dma_halt_flags dma_halt_flags_chk #(
  .REG_W   (REG_W),
  .ERR_POS (ERR_POS),
  .NMI_POS (NMI_POS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_err_evt (addr_err_evt),
  .nmi_evt      (nmi_evt),
  .dma_active   (dma_active),
  .unit_done    (unit_done),
  .wr_stb       (wr_stb),
  .rd_data      (rd_data),
  .suspend_all  (suspend_all),
  .flags_q      (flags_q)
);

// File: tb/sim_dma_halt_flags.sv
module sim_dma_halt_flags;
  localparam int W  = 16;
  localparam int EP = 9;
  localparam int NP = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         addr_err_evt = 1'b0, nmi_evt = 1'b0, dma_active = 1'b0, unit_done = 1'b0;
  logic         rd_stb = 1'b0, wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         suspend_all;

  always #5 clk = ~clk;

  dma_halt_flags #(.REG_W(W), .ERR_POS(EP), .NMI_POS(NP)) u0 (
    .clk(clk), .rst(rst), .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt),
    .dma_active(dma_active), .unit_done(unit_done), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .suspend_all(suspend_all)
  );

  typedef struct {
    string        tag;
    bit           chk;
    logic [W-1:0] rd;
    logic         sus;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_vec  = 0;
  int   n_miss = 0;
  bit   done   = 0;

  function automatic logic [W-1:0] pk(input bit e, input bit n);
    logic [W-1:0] v = '0;
    v[EP] = e;
    v[NP] = n;
    return v;
  endfunction

  // Driver: applies one cycle of stimulus and queues the state expected after the edge.
  task automatic tick(input bit e, input bit n, input bit act, input bit dn,
                      input bit rd, input bit wr, input logic [W-1:0] wd,
                      input string tag, input bit chk, input bit xsus, input logic [W-1:0] xrd);
    exp_t it;
    @(negedge clk);
    addr_err_evt = e; nmi_evt = n; dma_active = act; unit_done = dn;
    rd_stb = rd; wr_stb = wr; wr_data = wd;
    it.tag = tag; it.chk = chk; it.rd = xrd; it.sus = xsus;
    q.push_back(it);
  endtask

  // Monitor: compares outputs just after each edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      if (cur.chk) begin
        n_vec++;
        if (rd_data !== cur.rd || suspend_all !== cur.sus) begin
          n_miss++;
          $display("FAIL %s: rd_data=%h suspend_all=%b expected rd_data=%h suspend_all=%b",
                   cur.tag, rd_data, suspend_all, cur.rd, cur.sus);
        end
      end
    end
  end

  localparam logic [W-1:0] Z = '0;
  localparam logic [W-1:0] ONES = '1;

  initial begin
    tick(0,0,0,0,0,0,Z,"reset",0,0,Z);
    tick(0,0,0,0,0,0,Z,"reset",0,0,Z);
    @(negedge clk); rst = 1'b0;
    q.delete();
    tick(0,0,0,0,0,0,Z,"R10 reset state",1,0,Z);
    tick(1,0,0,0,0,0,Z,"R2 fault suspends",1,1,Z);
    tick(0,0,0,0,1,0,Z,"R1 fault flag read",1,1,pk(1,0));
    tick(0,0,0,0,0,1,ONES,"R5 write ones keeps flag",1,1,pk(1,0));
    tick(0,0,0,0,0,1,Z,"R7 write after write",1,1,pk(1,0));
    tick(0,0,0,0,1,0,Z,"R7 flag survived",1,1,pk(1,0));
    tick(0,0,0,0,0,1,Z,"R6 armed clear",1,0,pk(1,0));
    tick(0,0,0,0,1,0,Z,"R6 cleared read",1,0,Z);
    tick(0,0,0,0,1,0,Z,"R6 read of zero",1,0,Z);
    tick(1,0,0,0,0,0,Z,"R2 fault again",1,1,Z);
    tick(0,0,0,0,0,1,Z,"R6 unarmed write",1,1,Z);
    tick(0,0,0,0,1,0,Z,"R6 unarmed flag kept",1,1,pk(1,0));
    tick(1,0,0,0,0,1,Z,"R8 set wins over clear",1,1,pk(1,0));
    tick(0,0,0,0,1,0,Z,"R8 flag still set",1,1,pk(1,0));
    tick(0,0,0,0,0,1,Z,"R9 release after fault",1,0,pk(1,0));
    tick(0,1,0,0,0,0,Z,"R4 interrupt while idle",1,1,pk(1,0));
    tick(0,0,0,0,1,0,Z,"R3 interrupt flag idle",1,1,pk(0,1));
    tick(0,0,0,0,0,1,Z,"R9 release interrupt",1,0,pk(0,1));
    tick(0,1,1,0,0,0,Z,"R4 interrupt waits",1,0,pk(0,1));
    tick(0,0,1,0,0,0,Z,"R4 still waiting",1,0,pk(0,1));
    tick(0,0,1,0,1,0,Z,"R3 interrupt flag active",1,0,pk(0,1));
    tick(0,0,1,1,0,0,Z,"R4 unit done halts",1,1,pk(0,1));
    tick(0,0,0,0,0,1,Z,"R9 release after unit",1,0,pk(0,1));
    tick(1,1,0,0,0,0,Z,"R2 both events",1,1,pk(0,1));
    tick(0,0,0,0,1,0,Z,"R10 both flags read",1,1,pk(1,1));
    tick(0,0,0,0,0,1,pk(0,1),"R9 one flag left holds",1,1,pk(1,1));
    tick(0,0,0,0,1,0,Z,"R9 fault gone",1,1,pk(0,1));
    tick(0,0,0,0,0,1,Z,"R9 last flag clears",1,0,pk(0,1));
    tick(0,0,0,0,0,1,ONES,"R5 ones on clear flags",1,0,pk(0,1));
    tick(0,0,0,0,1,0,Z,"R5 flags stay clear",1,0,Z);
    tick(0,0,0,0,0,0,Z,"R10 read data holds",1,0,Z);
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule